// File: doc/BRIEF.md
# Wakeup Timer Counter with Sticky Events

This block keeps the time base of a wakeup timer. A prescaled, gated tick, already brought into the system clock domain as a one-cycle pulse, advances a wide real-time count and a parallel count that runs modulo a small period (sixty by default). A trim pulse that arrives with a tick can either add an extra count or skip the count on that tick. Both counters share that trimmed step.

Each tick is classified into five events: the count changed, the tick fired, a trim was applied, the wide count wrapped, and the modulo count wrapped. Every event latches into a sticky flag. Software clears a flag by writing 1 to its bit. Each flag has an enable bit, and the enabled flags are combined into one registered, level-sensitive interrupt.

Next to the sticky flags, two live rollover bits show whether the value currently held by each counter came from a wrap at the most recent tick. After an interrupt, software can read these bits to tell whether the count it reads still reflects that rollover or has moved on. The register port is a plain single-cycle write strobe with a combinational read. There is no data stream, so no valid/ready handshake is needed.

Top module: `wakeup_timer`

## Requirements
- R1: After reset, the count, the modulo count, the status word, the enable word and `irq` all read 0.
- R2: On a cycle with `tick` high, the count (address 0, zero-extended) advances by a step: 2 when only `trim_add` is high, 0 when only `trim_skip` is high, otherwise 1. The count wraps modulo 2^CNT_W. Without `tick`, the count holds and the trim inputs have no effect.
- R3: The modulo count (address 1) advances by the same step on each tick, modulo MOD. It never leaves the range 0 to MOD-1.
- R4: Status bit 5 is the live count rollover. On every tick it is loaded with whether that tick's addition passed the top of the count range. Between ticks it holds.
- R5: Status bit 6 is the live modulo rollover. On every tick it is loaded with whether that tick's addition passed MOD-1 back to 0 or 1. Between ticks it holds.
- R6: Status bits 4:0 are sticky flags. The bit positions are: 0 = count changed (tick with non-zero step), 1 = tick seen, 2 = trim seen (tick with `trim_add` or `trim_skip`), 3 = count wrap, 4 = modulo wrap. Once set, a flag stays set until software clears it.
- R7: Writing to address 2 clears each sticky flag whose data bit is 1 and leaves the others unchanged. If a set and a clear reach the same flag in the same cycle, the flag ends set.
- R8: Address 3 holds a 5-bit enable word with the same bit order as the flags. It is written and read back. `irq` equals, one clock later, the OR over all bits of (flag AND enable).
- R9: Writes to addresses 0 and 1 have no effect on either count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle prescaled tick pulse |
| trim_add | input | 1 | With tick: advance one extra count |
| trim_skip | input | 1 | With tick: withhold the count |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 count, 1 modulo, 2 status, 3 enable) |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 2 | Read address, same map |
| rd_data | output | DATA_W | Combinational read data |
| irq | output | 1 | Registered level interrupt |

## Verification
The bench runs the design with an 8-bit count so that a run of plain ticks passes through several full wraps. This shows the live count rollover rising on exactly one tick and falling on the next. A pseudo-random stretch then mixes tick gaps with add, skip and add-plus-skip trims. These patterns separate a step of 0, 1 and 2, and they reach the modulo boundary at 58 and 59 so that a two-count step can wrap to 1. Interleaved clears and enable changes, a clear that coincides with a tick, trims without a tick, and writes to the count addresses show whether the flags, the interrupt and the counts react only to what the requirements allow.

// File: rtl/wkt_pkg.sv
package wkt_pkg;
  localparam int EV_N      = 5;
  localparam int EV_CHG    = 0;
  localparam int EV_TICK   = 1;
  localparam int EV_TRIM   = 2;
  localparam int EV_WRAP   = 3;
  localparam int EV_MWRAP  = 4;

  localparam logic [1:0] A_CNT  = 2'd0;
  localparam logic [1:0] A_MOD  = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;
  localparam logic [1:0] A_EN   = 2'd3;

  // step encoding shared by both counters
  function automatic logic [1:0] trim_step(input logic add, input logic skip);
    if (add && !skip)      trim_step = 2'd2;
    else if (skip && !add) trim_step = 2'd0;
    else                   trim_step = 2'd1;
  endfunction
endpackage

// File: rtl/wkt_count.sv
module wkt_count #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [1:0]   step,
  output logic [W-1:0] cnt_q,
  output logic         live_q,
  output logic         wrap_now
);
  logic [W:0] sum;

  assign sum      = {1'b0, cnt_q} + {{(W-1){1'b0}}, step};
  assign wrap_now = tick & sum[W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      live_q <= 1'b0;
    end else if (tick) begin
      cnt_q  <= sum[W-1:0];
      live_q <= sum[W];
    end
  end
endmodule

// File: rtl/wkt_mod.sv
module wkt_mod #(
  parameter int MOD = 60,
  parameter int MW  = $clog2(MOD)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [1:0]    step,
  output logic [MW-1:0] mod_q,
  output logic          live_q,
  output logic          wrap_now
);
  localparam logic [MW:0] LIMIT = (MW+1)'(MOD);

  logic [MW:0] sum;
  logic [MW:0] folded;
  logic        over;

  assign sum      = {1'b0, mod_q} + {{(MW-1){1'b0}}, step};
  assign over     = (sum >= LIMIT);
  assign folded   = over ? (sum - LIMIT) : sum;
  assign wrap_now = tick & over;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_q  <= '0;
      live_q <= 1'b0;
    end else if (tick) begin
      mod_q  <= folded[MW-1:0];
      live_q <= over;
    end
  end
endmodule

// File: rtl/wkt_sticky.sv
module wkt_sticky #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] flag_q,
  output logic         irq_q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_q[i] <= 1'b0;
      else if (set_i[i]) flag_q[i] <= 1'b1;
      else if (clr_i[i]) flag_q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(flag_q & en_i);
  end
endmodule

// File: rtl/wakeup_timer.sv
module wakeup_timer
  import wkt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int MOD    = 60,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              trim_add,
  input  logic              trim_skip,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  localparam int MOD_W = $clog2(MOD);

  logic [1:0]       step;
  logic [CNT_W-1:0] cnt_q;
  logic [MOD_W-1:0] mod_q;
  logic             live_cnt, live_mod, wrap_cnt, wrap_mod;
  logic [EV_N-1:0]  ev_set, ev_clr, en_q, sticky_q;

  assign step = trim_step(trim_add, trim_skip);

  wkt_count #(.W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .tick(tick), .step(step),
    .cnt_q(cnt_q), .live_q(live_cnt), .wrap_now(wrap_cnt)
  );

  wkt_mod #(.MOD(MOD), .MW(MOD_W)) u_mod (
    .clk(clk), .rst_n(rst_n), .tick(tick), .step(step),
    .mod_q(mod_q), .live_q(live_mod), .wrap_now(wrap_mod)
  );

  always_comb begin
    ev_set           = '0;
    ev_set[EV_CHG]   = tick & (step != 2'd0);
    ev_set[EV_TICK]  = tick;
    ev_set[EV_TRIM]  = tick & (trim_add | trim_skip);
    ev_set[EV_WRAP]  = wrap_cnt;
    ev_set[EV_MWRAP] = wrap_mod;
  end

  assign ev_clr = (wr_en && wr_addr == A_STAT) ? wr_data[EV_N-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       en_q <= '0;
    else if (wr_en && wr_addr == A_EN) en_q <= wr_data[EV_N-1:0];
  end

  wkt_sticky #(.N(EV_N)) u_sticky (
    .clk(clk), .rst_n(rst_n), .set_i(ev_set), .clr_i(ev_clr),
    .en_i(en_q), .flag_q(sticky_q), .irq_q(irq)
  );

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      A_CNT:  rd_data = DATA_W'(cnt_q);
      A_MOD:  rd_data = DATA_W'(mod_q);
      A_STAT: rd_data = DATA_W'({live_mod, live_cnt, sticky_q});
      A_EN:   rd_data = DATA_W'(en_q);
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/wakeup_timer_chk.sv
module wakeup_timer_chk #(
  parameter int CNT_W  = 32,
  parameter int MOD    = 60,
  parameter int DATA_W = 32,
  parameter int MOD_W  = $clog2(MOD)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [MOD_W-1:0]  mod_q,
  input logic              live_cnt,
  input logic              live_mod,
  input logic [4:0]        sticky_q,
  input logic [4:0]        en_q,
  input logic              irq
);
  logic [4:0] keep;
  assign keep = sticky_q & ~((wr_en && wr_addr == 2'd2) ? wr_data[4:0] : 5'd0);

  a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));
  a_r3_mod_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    mod_q < MOD_W'(MOD));
  a_r4_live_cnt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(live_cnt));
  a_r5_live_mod_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(live_mod));
  a_r6_sticky_kept: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sticky_q & $past(keep)) == $past(keep)));
  a_r7_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> sticky_q[1]);
  a_r8_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|(sticky_q & en_q)));
endmodule

bind wakeup_timer wakeup_timer_chk #(.CNT_W(CNT_W), .MOD(MOD), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .cnt_q(cnt_q), .mod_q(mod_q), .live_cnt(live_cnt),
  .live_mod(live_mod), .sticky_q(sticky_q), .en_q(en_q), .irq(irq)
);

// File: tb/test_wakeup_timer.sv
module test_wakeup_timer;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W  = 8;
  localparam int MOD    = 60;
  localparam int DATA_W = 32;
  localparam int SPAN   = 1 << CNT_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, trim_add = 0, trim_skip = 0, wr_en = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [DATA_W-1:0] wr_data = 0, rd_data;
  logic irq;

  int total = 0, bad = 0;
  int m_cnt = 0, m_mod = 0;
  logic [4:0] m_sticky = 0, m_en = 0;
  logic m_live_c = 0, m_live_m = 0, m_irq = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  wakeup_timer #(.CNT_W(CNT_W), .MOD(MOD), .DATA_W(DATA_W)) i_wakeup_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .trim_add(trim_add),
    .trim_skip(trim_skip), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    rd_addr = 2'd0; #1; check({tag, " R2 count"}, rd_data, 32'(m_cnt));
    rd_addr = 2'd1; #1; check({tag, " R3 modulo"}, rd_data, 32'(m_mod));
    rd_addr = 2'd2; #1; check({tag, " R4 R5 R6 R7 status"}, rd_data,
                              {25'd0, m_live_m, m_live_c, m_sticky});
    rd_addr = 2'd3; #1; check({tag, " R8 enable"}, rd_data, {27'd0, m_en});
    check({tag, " R8 irq"}, {31'd0, irq}, {31'd0, m_irq});
  endtask

  task automatic cyc(input logic t, input logic a, input logic s, input logic we,
                     input logic [1:0] wa, input logic [31:0] wd, input string tag);
    int stp, sum, msum;
    logic wrap, mwrap;
    logic [4:0] set, clr;
    tick = t; trim_add = a; trim_skip = s; wr_en = we; wr_addr = wa; wr_data = wd;
    @(posedge clk);
    stp   = t ? (1 + int'(a) - int'(s)) : 0;
    sum   = m_cnt + stp;
    msum  = m_mod + stp;
    wrap  = t && (sum >= SPAN);
    mwrap = t && (msum >= MOD);
    set   = {mwrap, wrap, t & (a | s), t, t && (stp != 0)};
    clr   = (we && wa == 2'd2) ? wd[4:0] : 5'd0;
    m_irq    = |(m_sticky & m_en);
    m_sticky = (m_sticky & ~clr) | set;
    if (we && wa == 2'd3) m_en = wd[4:0];
    if (t) begin
      m_cnt = sum % SPAN; m_mod = msum % MOD;
      m_live_c = wrap; m_live_m = mwrap;
    end
    @(negedge clk);
    tick = 0; trim_add = 0; trim_skip = 0; wr_en = 0;
    check_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_all("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 after release");

    // plain ticks through more than one full wrap of the 8-bit count
    for (int i = 0; i < 2 * SPAN + 20; i++) cyc(1, 0, 0, 0, 0, 0, "plain");

    // enable everything, clear everything, then idle: irq follows
    cyc(0, 0, 0, 1, 2'd3, 32'h1F, "R8 enable all");
    cyc(0, 0, 0, 1, 2'd2, 32'h1F, "R7 clear all");
    cyc(0, 0, 0, 0, 0, 0, "R8 irq drops");
    // clear colliding with a tick: set wins
    cyc(1, 0, 0, 1, 2'd2, 32'h1F, "R7 collision");
    // trims without tick are ignored
    cyc(0, 1, 0, 0, 0, 0, "R2 add no tick");
    cyc(0, 0, 1, 0, 0, 0, "R2 skip no tick");
    // writes to count addresses ignored
    cyc(0, 0, 0, 1, 2'd0, 32'hFF, "R9 write count");
    cyc(0, 0, 0, 1, 2'd1, 32'h3B, "R9 write modulo");
    // partial clear
    cyc(0, 0, 0, 1, 2'd2, 32'h05, "R7 partial clear");

    // mixed pseudo-random sweep with trims, gaps, clears and enables
    for (int i = 0; i < 900; i++) begin
      logic t, a, s, we;
      logic [1:0] wa;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      t  = lfsr[0] | lfsr[1];
      a  = lfsr[2] & lfsr[3];
      s  = lfsr[4] & lfsr[5];
      we = (i % 11 == 0);
      wa = (i % 22 == 0) ? 2'd3 : 2'd2;
      cyc(t, a, s, we, wa, {27'd0, lfsr[10:6]}, "R6 sweep");
    end

    // drive the modulo count to 58 and add two: wraps to 0 with trim
    while (m_mod != 58) cyc(1, 0, 0, 0, 0, 0, "R3 approach");
    cyc(1, 1, 0, 0, 0, 0, "R5 wrap by two");
    while (m_mod != 59) cyc(1, 0, 0, 0, 0, 0, "R3 approach");
    cyc(1, 1, 0, 0, 0, 0, "R5 wrap to one");
    cyc(1, 0, 1, 0, 0, 0, "R5 skip clears live");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule